// File: doc/BRIEF.md
# Profiling Buffer Syndrome Capture Register

This block holds the 64-bit status word that a profiling-buffer writer fills in when a management event halts collection. The writer presents an event as a typed report: a kind (generic buffer event, or a data abort on a buffer write at translation stage 1 or stage 2), a fault type with a table level, a buffer-full flag and a partial-record-lost flag. The block turns that report into a two-level cause: a class code in the upper field and a sub-syndrome in the low field whose layout depends on the class. A separate collision strobe can set a sticky collision bit at any time.

Capturing an event sets the service bit, and the management interrupt follows that bit directly. Software reads the whole word on `rd_data` at any time. It acknowledges the event by writing the word back, usually with the service bit cleared. Writes are filtered so that reserved codes and reserved bit ranges never reach the stored value. A small two-state controller tracks the service condition. In ST_ARMED no event is held. In ST_SERVICE one event is held and the interrupt is asserted. A valid capture moves ST_ARMED to ST_SERVICE. A software write moves either state to the state named by bit 17 of the written data. An event that arrives in ST_SERVICE leaves the state unchanged.

Top module: `psr_syndrome_reg`

## Requirements
- R1: `rd_data` bits 63:32 and 25:20 always read 0. The class code is in bits 31:26, partial-loss in bit 19, external-abort in bit 18, service in bit 17, collision in bit 16, and the sub-syndrome in bits 15:0. Sub-syndrome bits 15:6 are always 0.
- R2: A captured event sets the class code by `evt_kind`. Kind 0 (generic) gives 0x00, kind 1 (stage-1 abort) gives 0x24, and kind 2 (stage-2 abort) gives 0x25.
- R3: For abort kinds, sub-syndrome bits 5:0 take a fault code from `evt_ftype`, where LL is `evt_level`. The codes are: 0 address-size = 0000LL, 1 translation = 0001LL, 2 access-flag = 0010LL, 3 permission = 0011LL, 4 synchronous external abort on write = 010000, 5 external abort on table walk = 0101LL, 6 asynchronous external abort on write = 010001, 7 alignment = 100001, 8 TLB conflict = 110000, 9 unsupported atomic update = 110001.
- R4: For the generic kind, sub-syndrome bits 5:0 are 000001 when `evt_full` is 1 and 000000 when it is 0.
- R5: The external-abort bit is captured as 1 for fault types 4, 5 and 6 and as 0 otherwise. The partial-loss bit is captured as `evt_partial`, and it is forced to 1 for fault type 6.
- R6: `irq` equals the service bit at all times. An accepted capture sets the service bit, and both are visible after the next clock edge.
- R7: The collision bit is set by `evt_coll` in any state. It stays 1 until a software write stores bit 16 of the written data.
- R8: A software write stores the class as 0 if it is not 0x00, 0x24 or 0x25. With an abort class, a fault code outside the R3 list is stored as 0. With the generic class, a status code other than 0 or 1 is stored as 0. Service and collision are stored as written.
- R9: A software write in the same cycle as an event takes priority. The stored value is the filtered write, and the event and the collision strobe are dropped.
- R10: While the service bit is 1, new events leave the class, partial-loss, external-abort and sub-syndrome fields unchanged. The first event is held.
- R11: After reset `rd_data` is 0 and `irq` is 0.
- R12: An event of kind 3, or an abort kind with `evt_ftype` above 9, is ignored. It changes neither the fields nor the service bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_valid | input | 1 | Event report strobe |
| evt_kind | input | 2 | Event kind: 0 generic, 1 stage-1 abort, 2 stage-2 abort, 3 none |
| evt_ftype | input | 4 | Fault type index (see R3) |
| evt_level | input | 2 | Translation table level |
| evt_full | input | 1 | Buffer full (generic kind) |
| evt_partial | input | 1 | Last record partially lost |
| evt_coll | input | 1 | Collision strobe |
| sw_wr_en | input | 1 | Software write enable |
| sw_wr_data | input | 64 | Software write data |
| rd_data | output | 64 | Current register value |
| irq | output | 1 | Level management interrupt |

## Verification
Every result lands in a register on the clock edge that samples the stimulus. Both `rd_data` and `irq` are combinational from that register, so each outcome is due exactly one edge after the inputs are driven. The bench drives inputs just after a rising edge and samples just after the following rising edge. This way each check sees the cycle its stimulus caused, and for the same-cycle priority case the event and the write land on one edge. For "ignored" and "held" cases, the check reads the full word on the edge after the event, where any change would have appeared.

// File: rtl/psr_pkg.sv
package psr_pkg;
    localparam int REG_W   = 64;
    localparam int CLS_W   = 6;
    localparam int MSS_W   = 16;
    localparam int CODE_W  = 6;
    localparam int FT_W    = 4;
    localparam int LVL_W   = 2;

    localparam logic [CLS_W-1:0] CLS_GENERIC = 6'h00;
    localparam logic [CLS_W-1:0] CLS_S1_ABT  = 6'h24;
    localparam logic [CLS_W-1:0] CLS_S2_ABT  = 6'h25;

    typedef enum logic [1:0] {
        EK_GENERIC = 2'd0,
        EK_S1_ABT  = 2'd1,
        EK_S2_ABT  = 2'd2,
        EK_NONE    = 2'd3
    } evt_kind_e;

    typedef enum logic {
        ST_ARMED   = 1'b0,
        ST_SERVICE = 1'b1
    } svc_state_e;

    typedef struct packed {
        logic [CLS_W-1:0] cls;
        logic             dl;
        logic             ea;
        logic [MSS_W-1:0] mss;
    } syn_fields_t;

    function automatic logic fault_code_ok(input logic [CODE_W-1:0] c);
        logic ok;
        ok = (c[5:4] == 2'b00) || (c[5:2] == 4'b0101) ||
             (c == 6'h10) || (c == 6'h11) || (c == 6'h21) ||
             (c == 6'h30) || (c == 6'h31);
        return ok;
    endfunction
endpackage

// File: rtl/psr_event_encode.sv
module psr_event_encode
    import psr_pkg::*;
(
    input  logic [1:0]       kind,
    input  logic [FT_W-1:0]  ftype,
    input  logic [LVL_W-1:0] level,
    input  logic             full,
    input  logic             partial,
    output syn_fields_t      fields,
    output logic             accept
);
    logic [CODE_W-1:0] code;
    logic              code_ok;
    logic              ext_abt;
    logic              async_abt;

    always_comb begin
        code      = '0;
        code_ok   = 1'b1;
        ext_abt   = 1'b0;
        async_abt = 1'b0;
        unique case (ftype)
            4'd0: code = {4'b0000, level};
            4'd1: code = {4'b0001, level};
            4'd2: code = {4'b0010, level};
            4'd3: code = {4'b0011, level};
            4'd4: begin code = 6'h10; ext_abt = 1'b1; end
            4'd5: begin code = {4'b0101, level}; ext_abt = 1'b1; end
            4'd6: begin code = 6'h11; ext_abt = 1'b1; async_abt = 1'b1; end
            4'd7: code = 6'h21;
            4'd8: code = 6'h30;
            4'd9: code = 6'h31;
            default: code_ok = 1'b0;
        endcase
    end

    always_comb begin
        fields = '0;
        accept = 1'b0;
        unique case (evt_kind_e'(kind))
            EK_GENERIC: begin
                accept        = 1'b1;
                fields.cls    = CLS_GENERIC;
                fields.mss[0] = full;
                fields.dl     = partial;
            end
            EK_S1_ABT, EK_S2_ABT: begin
                accept     = code_ok;
                fields.cls = (evt_kind_e'(kind) == EK_S1_ABT) ? CLS_S1_ABT : CLS_S2_ABT;
                fields.mss[CODE_W-1:0] = code;
                fields.ea  = ext_abt;
                fields.dl  = partial | async_abt;
            end
            EK_NONE: accept = 1'b0;
        endcase
    end
endmodule

// File: rtl/psr_write_filter.sv
module psr_write_filter
    import psr_pkg::*;
(
    input  logic [REG_W-1:0] wdata,
    output syn_fields_t      fields,
    output logic             svc,
    output logic             coll
);
    logic [CLS_W-1:0]  cls_in;
    logic [CODE_W-1:0] code_in;

    assign cls_in  = wdata[31:26];
    assign code_in = wdata[CODE_W-1:0];
    assign svc     = wdata[17];
    assign coll    = wdata[16];

    always_comb begin
        fields    = '0;
        fields.dl = wdata[19];
        fields.ea = wdata[18];
        if (cls_in == CLS_S1_ABT || cls_in == CLS_S2_ABT) begin
            fields.cls = cls_in;
            fields.mss[CODE_W-1:0] = fault_code_ok(code_in) ? code_in : '0;
        end else begin
            fields.cls = CLS_GENERIC;
            fields.mss[CODE_W-1:0] = (code_in <= 6'd1) ? code_in : '0;
        end
    end
endmodule

// File: rtl/psr_syndrome_reg.sv
module psr_syndrome_reg
    import psr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             evt_valid,
    input  logic [1:0]       evt_kind,
    input  logic [3:0]       evt_ftype,
    input  logic [1:0]       evt_level,
    input  logic             evt_full,
    input  logic             evt_partial,
    input  logic             evt_coll,
    input  logic             sw_wr_en,
    input  logic [63:0]      sw_wr_data,
    output logic [63:0]      rd_data,
    output logic             irq
);
    svc_state_e  state_q, state_d;
    syn_fields_t fld_q, enc_fields, wr_fields;
    logic        coll_q;
    logic        enc_accept, wr_svc, wr_coll, capture;

    psr_event_encode u_enc (
        .kind    (evt_kind),
        .ftype   (evt_ftype),
        .level   (evt_level),
        .full    (evt_full),
        .partial (evt_partial),
        .fields  (enc_fields),
        .accept  (enc_accept)
    );

    psr_write_filter u_wf (
        .wdata  (sw_wr_data),
        .fields (wr_fields),
        .svc    (wr_svc),
        .coll   (wr_coll)
    );

    assign capture = evt_valid && enc_accept && !sw_wr_en && (state_q == ST_ARMED);

    always_comb begin
        state_d = state_q;
        if (sw_wr_en) begin
            state_d = wr_svc ? ST_SERVICE : ST_ARMED;
        end else begin
            unique case (state_q)
                ST_ARMED:   if (evt_valid && enc_accept) state_d = ST_SERVICE;
                ST_SERVICE: state_d = ST_SERVICE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_ARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fld_q  <= '0;
            coll_q <= 1'b0;
        end else if (sw_wr_en) begin
            fld_q  <= wr_fields;
            coll_q <= wr_coll;
        end else begin
            if (evt_coll) coll_q <= 1'b1;
            if (capture)  fld_q  <= enc_fields;
        end
    end

    always_comb begin
        irq     = (state_q == ST_SERVICE);
        rd_data = {32'b0, fld_q.cls, 6'b0, fld_q.dl, fld_q.ea, irq, coll_q,
                   10'b0, fld_q.mss[CODE_W-1:0]};
    end
endmodule

// File: rtl/psr_syndrome_chk.sv
module psr_syndrome_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        evt_valid,
    input logic [1:0]  evt_kind,
    input logic [3:0]  evt_ftype,
    input logic        evt_coll,
    input logic        sw_wr_en,
    input logic [63:0] sw_wr_data,
    input logic [63:0] rd_data,
    input logic        irq
);
    logic ev_ok;
    assign ev_ok = evt_valid && (evt_kind == 2'd0 ||
                   ((evt_kind == 2'd1 || evt_kind == 2'd2) && evt_ftype <= 4'd9));

    AST_IRQ_FOLLOWS_SVC: assert property (@(posedge clk) disable iff (!rst_n)
        irq == rd_data[17]); // R6
    AST_CAPTURE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_ok && !sw_wr_en) |=> irq); // R6
    AST_COLL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_data[16] || evt_coll) && !sw_wr_en) |=> rd_data[16]); // R7
    AST_HOLD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !sw_wr_en) |=> ($stable(rd_data[31:18]) && $stable(rd_data[15:0]))); // R10
    AST_ASYNC_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !sw_wr_en && evt_valid && evt_kind != 2'd0 && evt_kind != 2'd3
         && evt_ftype == 4'd6) |=> (rd_data[19] && rd_data[18])); // R5
    AST_RSVD_CLASS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_wr_en && sw_wr_data[31:26] != 6'h00 && sw_wr_data[31:26] != 6'h24
         && sw_wr_data[31:26] != 6'h25) |=> rd_data[31:26] == 6'h00); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        sw_wr_en |=> (irq == $past(sw_wr_data[17]) && rd_data[16] == $past(sw_wr_data[16]))); // R9
    AST_IDLE_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq && !sw_wr_en && !ev_ok) |=> (!irq && $stable(rd_data[31:18]))); // R12
endmodule

bind psr_syndrome_reg psr_syndrome_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_valid  (evt_valid),
    .evt_kind   (evt_kind),
    .evt_ftype  (evt_ftype),
    .evt_coll   (evt_coll),
    .sw_wr_en   (sw_wr_en),
    .sw_wr_data (sw_wr_data),
    .rd_data    (rd_data),
    .irq        (irq)
);

// File: tb/tb_psr_syndrome_reg.sv
`timescale 1ns/1ps
module tb_psr_syndrome_reg;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        evt_valid, evt_full, evt_partial, evt_coll, sw_wr_en;
    logic [1:0]  evt_kind, evt_level;
    logic [3:0]  evt_ftype;
    logic [63:0] sw_wr_data, rd_data;
    logic        irq;
    int          total = 0;
    int          bad   = 0;

    always #2.5 clk = ~clk;

    psr_syndrome_reg dut (
        .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
        .evt_ftype(evt_ftype), .evt_level(evt_level), .evt_full(evt_full),
        .evt_partial(evt_partial), .evt_coll(evt_coll), .sw_wr_en(sw_wr_en),
        .sw_wr_data(sw_wr_data), .rd_data(rd_data), .irq(irq)
    );

    function automatic logic [63:0] mk(input logic [5:0] cls, input logic dl,
        input logic ea, input logic svc, input logic coll, input logic [5:0] code);
        return {32'b0, cls, 6'b0, dl, ea, svc, coll, 10'b0, code};
    endfunction

    function automatic logic [5:0] fcode(input int ft, input logic [1:0] l);
        case (ft)
            0: return {4'b0000, l};
            1: return {4'b0001, l};
            2: return {4'b0010, l};
            3: return {4'b0011, l};
            4: return 6'h10;
            5: return {4'b0101, l};
            6: return 6'h11;
            7: return 6'h21;
            8: return 6'h30;
            default: return 6'h31;
        endcase
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic idle();
        evt_valid = 0; evt_kind = 0; evt_ftype = 0; evt_level = 0;
        evt_full = 0; evt_partial = 0; evt_coll = 0; sw_wr_en = 0; sw_wr_data = '0;
    endtask

    task automatic step();
        @(posedge clk); #1;
        idle();
    endtask

    task automatic ev(input logic [1:0] k, input logic [3:0] ft, input logic [1:0] l,
                      input logic full, input logic part);
        evt_valid = 1; evt_kind = k; evt_ftype = ft; evt_level = l;
        evt_full = full; evt_partial = part;
        step();
    endtask

    task automatic wr(input logic [63:0] d);
        sw_wr_en = 1; sw_wr_data = d;
        step();
    endtask

    task automatic t_reset();
        chk("R11 rd_data", rd_data, 64'h0);
        chk("R11 irq", {63'b0, irq}, 64'h0);
    endtask

    task automatic t_generic();
        ev(2'd0, 4'd0, 2'd0, 1'b1, 1'b0);
        chk("R2 R4 generic full", rd_data, mk(6'h00, 0, 0, 1, 0, 6'h01));
        chk("R6 irq set", {63'b0, irq}, 64'h1);
        wr(64'h0);
        chk("R6 irq clear", {63'b0, irq}, 64'h0);
        ev(2'd0, 4'd0, 2'd0, 1'b0, 1'b1);
        chk("R4 R5 generic not full", rd_data, mk(6'h00, 1, 0, 1, 0, 6'h00));
        wr(64'h0);
    endtask

    task automatic t_faults();
        for (int ft = 0; ft < 10; ft++) begin
            logic ea;
            ea = (ft == 4 || ft == 5 || ft == 6);
            ev(2'd1, 4'(ft), 2'd2, 1'b0, 1'b0);
            chk($sformatf("R3 R5 s1 ftype %0d", ft), rd_data,
                mk(6'h24, ft == 6, ea, 1, 0, fcode(ft, 2'd2)));
            wr(64'h0);
        end
        ev(2'd2, 4'd1, 2'd3, 1'b0, 1'b1);
        chk("R2 R3 s2 translation", rd_data, mk(6'h25, 1, 0, 1, 0, 6'h07));
        wr(64'h0);
    endtask

    task automatic t_hold();
        ev(2'd1, 4'd3, 2'd1, 1'b0, 1'b0);
        ev(2'd2, 4'd7, 2'd0, 1'b0, 1'b1);
        chk("R10 first event held", rd_data, mk(6'h24, 0, 0, 1, 0, 6'h0D));
        wr(64'h0);
    endtask

    task automatic t_coll();
        evt_coll = 1; step();
        chk("R7 coll set idle", rd_data, mk(6'h00, 0, 0, 0, 1, 6'h00));
        ev(2'd0, 4'd0, 2'd0, 1'b1, 1'b0);
        chk("R7 coll kept over capture", rd_data, mk(6'h00, 0, 0, 1, 1, 6'h01));
        wr(64'h0002_0001);
        chk("R7 coll cleared by write", rd_data, mk(6'h00, 0, 0, 1, 0, 6'h01));
        wr(64'h0);
    endtask

    task automatic t_conflict();
        evt_valid = 1; evt_kind = 2'd1; evt_ftype = 4'd6; evt_coll = 1;
        sw_wr_en = 1; sw_wr_data = 64'h0;
        step();
        chk("R9 write beats event", rd_data, 64'h0);
    endtask

    task automatic t_rsvd();
        wr(64'hFFFF_FFFF_FC3F_FFFF);
        chk("R8 R1 bad class", rd_data, mk(6'h00, 1, 1, 1, 1, 6'h00));
        wr(mk(6'h24, 0, 0, 0, 0, 6'h3F));
        chk("R8 bad fault code", rd_data, mk(6'h24, 0, 0, 0, 0, 6'h00));
        wr(mk(6'h00, 0, 0, 0, 0, 6'h05));
        chk("R8 bad status code", rd_data, 64'h0);
        wr(64'hFFFF_FFFF_97F2_FFD1);
        chk("R8 R1 valid write kept", rd_data, mk(6'h25, 0, 0, 1, 0, 6'h11));
        chk("R6 irq from write", {63'b0, irq}, 64'h1);
        wr(64'h0);
    endtask

    task automatic t_ignore();
        ev(2'd3, 4'd0, 2'd0, 1'b1, 1'b1);
        chk("R12 kind 3 ignored", rd_data, 64'h0);
        ev(2'd1, 4'd12, 2'd0, 1'b0, 1'b1);
        chk("R12 bad ftype ignored", rd_data, 64'h0);
    endtask

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        t_reset();
        t_generic();
        t_faults();
        t_hold();
        t_coll();
        t_conflict();
        t_rsvd();
        t_ignore();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule